// File: doc/BRIEF.md
# Serial Management Target with Emulated PHY Registers

This block is the device side of a two-wire serial management bus of the clause-22 kind. A host toggles a management clock and shifts frames in on a data line. Each frame holds a long run of ones, a start pattern, a two-bit operation code, a five-bit device address, a five-bit register number, a two-cycle turnaround and sixteen data bits. The block samples the management clock in its own system clock domain and finds the clock edges there. It decodes each frame and serves a file of thirty-two sixteen-bit registers for one emulated PHY.

Most registers read back what was last written to them. The basic status register, the link-partner ability register and the diagnostic register are different: their read values are built from the advertisement register and from the link-up input. The five-bit address strap sets the PHY address. A frame sent to any other address is decoded in full but has no effect. On a read the block drives the data line through an output enable, and when it is not driving it holds its output at the released (high) level.

Top module: `mdio_phy_target`

## Requirements
- R1: After reset the output enable is low and the data output is high. Register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 reads 0x01E1 and every other stored register reads 0x0000.
- R2: A frame is accepted only after at least 32 consecutive clock rises with the data line high, followed by a rise with the data line low. The next rise is taken as the second start bit. A run of fewer than 32 ones resets the count, so the frame that follows is ignored.
- R3: The operation code, the address and the register number are sampled on clock rises, most significant bit first. Operation code 2'b10 is a read. The codes 2'b00, 2'b01 and 2'b11 are all writes.
- R4: On an addressed read, the output enable rises after the second turnaround rise and stays high until the sixteenth data rise. The data bits appear most significant bit first, and each one changes only while the clock is low.
- R5: On an addressed write, the sixteen data bits are taken on clock rises. The register is updated only after the sixteenth bit, and a later read returns the written value.
- R6: A frame whose address differs from the strap never raises the output enable and changes no register. A read of such an address therefore sees 0xFFFF from the released output.
- R7: Register 1 reads 0x782C while the link input is high and 0x0000 while it is low (bits 14, 13, 12, 11, 5, 3 and 2 set). A write to register 1 does not change what it reads.
- R8: Register 5 reads 0x4001 OR (register 4 AND 0x01E0).
- R9: Register 18 reads 0x0000 while the link input is low. While it is high, bit 10 equals reg4[7] OR reg4[8], bit 11 equals reg4[8] OR reg4[6], and all other bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the host, asynchronous to clk |
| mdio_i | input | 1 | Management data as seen on the bus |
| link_up_i | input | 1 | Link state of the emulated PHY |
| phy_addr_i | input | 5 | Address strap of the emulated PHY |
| mdio_o | output | 1 | Read data to the bus; high when released |
| mdio_oe_o | output | 1 | Output enable for mdio_o |

## Verification
The embedded assertions watch, on every cycle, the rules of the drive window. The enable is only ever high during the data field. It falls right after the last data rise. The driven bit moves only while the synchronized clock is low. The output sits high whenever it is not driven. A frame start is accepted only after a long enough run of ones, and every write pulse lands in the addressed register. Other behaviour can only be shown by the bench's frame scenarios, which compare against a behavioural model on every bit: the values of the computed registers under different advertisement and link settings, the fact that all three non-read codes act as writes, and the rejection of short preambles and foreign addresses.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;

  localparam int DW = 16;
  localparam int FW = 5;
  localparam int NREG = 1 << FW;

  localparam logic [1:0] OP_RD = 2'b10;

  localparam int REG_BMSR    = 1;
  localparam int REG_ADV     = 4;
  localparam int REG_PARTNER = 5;
  localparam int REG_DIAG    = 18;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_START,
    ST_OPC,
    ST_PHYAD,
    ST_REGAD,
    ST_TA,
    ST_DATA
  } frame_st_e;

  function automatic logic [DW-1:0] reg_reset(input int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic mdc_s_o,
  output logic mdio_s_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] mdc_ff_q, mdio_ff_q;
  logic              mdc_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_ff_q   <= '0;
      mdio_ff_q  <= '0;
      mdc_prev_q <= 1'b0;
    end else begin
      mdc_ff_q   <= {mdc_ff_q[STAGES-2:0], mdc_i};
      mdio_ff_q  <= {mdio_ff_q[STAGES-2:0], mdio_i};
      mdc_prev_q <= mdc_ff_q[STAGES-1];
    end
  end

  assign mdc_s_o  = mdc_ff_q[STAGES-1];
  assign mdio_s_o = mdio_ff_q[STAGES-1];
  assign rise_o   = mdc_ff_q[STAGES-1] & ~mdc_prev_q;
  assign fall_o   = ~mdc_ff_q[STAGES-1] & mdc_prev_q;

endmodule

// File: rtl/mdio_frame_dec.sv
module mdio_frame_dec
  import mdio_phy_pkg::*;
#(
  parameter int PRE_MIN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mdc_s_i,
  input  logic          mdio_s_i,
  input  logic [FW-1:0] phy_addr_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [FW-1:0] reg_idx_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic          mdio_o,
  output logic          mdio_oe_o
);

  localparam int PCW = $clog2(PRE_MIN + 1);
  localparam int CW  = $clog2(DW + 1);

  frame_st_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PCW-1:0] pre_q, pre_d;
  logic [1:0]    opc_q, opc_d;
  logic [FW-1:0] phy_q, phy_d;
  logic [FW-1:0] reg_q, reg_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          oe_q, oe_d;
  logic          out_q, out_d;
  logic          wr_q, wr_d;
  logic          ce;
  logic          last;
  logic          hit;
  int            field_len;

  assign ce  = rise_i | fall_i;
  assign hit = (phy_q == phy_addr_i);

  always_comb begin
    case (st_q)
      ST_OPC, ST_TA:     field_len = 2;
      ST_PHYAD, ST_REGAD: field_len = FW;
      ST_DATA:           field_len = DW;
      default:           field_len = 1;
    endcase
  end

  assign last = (cnt_q == CW'(field_len - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    pre_d = pre_q;
    opc_d = opc_q;
    phy_d = phy_q;
    reg_d = reg_q;
    sh_d  = sh_q;
    oe_d  = oe_q;
    out_d = out_q;
    wr_d  = 1'b0;
    if (rise_i) begin
      case (st_q)
        ST_PRE: begin
          if (mdio_s_i) begin
            if (pre_q < PCW'(PRE_MIN)) pre_d = pre_q + 1'b1;
          end else begin
            pre_d = '0;
            if (pre_q >= PCW'(PRE_MIN)) st_d = ST_START;
          end
        end
        ST_START: begin
          st_d  = ST_OPC;
          cnt_d = '0;
        end
        ST_OPC: begin
          opc_d = {opc_q[0], mdio_s_i};
          cnt_d = last ? '0 : cnt_q + 1'b1;
          if (last) st_d = ST_PHYAD;
        end
        ST_PHYAD: begin
          phy_d = {phy_q[FW-2:0], mdio_s_i};
          cnt_d = last ? '0 : cnt_q + 1'b1;
          if (last) st_d = ST_REGAD;
        end
        ST_REGAD: begin
          reg_d = {reg_q[FW-2:0], mdio_s_i};
          cnt_d = last ? '0 : cnt_q + 1'b1;
          if (last) st_d = ST_TA;
        end
        ST_TA: begin
          cnt_d = last ? '0 : cnt_q + 1'b1;
          if (last) begin
            st_d = ST_DATA;
            sh_d = '0;
            if (opc_q == OP_RD && hit) begin
              oe_d = 1'b1;
              sh_d = rd_data_i;
            end
          end
        end
        ST_DATA: begin
          if (!oe_q) sh_d = {sh_q[DW-2:0], mdio_s_i};
          cnt_d = last ? '0 : cnt_q + 1'b1;
          if (last) begin
            st_d  = ST_PRE;
            pre_d = '0;
            oe_d  = 1'b0;
            out_d = 1'b1;
            if (opc_q != OP_RD && hit) wr_d = 1'b1;
          end
        end
        default: st_d = ST_PRE;
      endcase
    end else if (fall_i && st_q == ST_DATA && oe_q) begin
      out_d = sh_q[DW-1];
      sh_d  = {sh_q[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PRE;
      cnt_q <= '0;
      pre_q <= '0;
      opc_q <= '0;
      phy_q <= '0;
      reg_q <= '0;
      sh_q  <= '0;
      oe_q  <= 1'b0;
      out_q <= 1'b1;
    end else if (ce) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pre_q <= pre_d;
      opc_q <= opc_d;
      phy_q <= phy_d;
      reg_q <= reg_d;
      sh_q  <= sh_d;
      oe_q  <= oe_d;
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_d;
  end

  assign reg_idx_o = reg_q;
  assign wr_en_o   = wr_q;
  assign wr_data_o = sh_q;
  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;

  // R2: leaving the preamble needs a full run of ones
  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && $past(st_q) == ST_PRE) |-> $past(pre_q) >= PCW'(PRE_MIN));

  // R4: the drive window lies inside the data field
  p_oe_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> st_q == ST_DATA);

  // R4: driven bits move only while the clock is low
  p_out_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && $past(oe_q) && !$stable(out_q)) |-> !mdc_s_i);

  // R4: drive released right after the last data rise
  p_oe_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && oe_q && st_q == ST_DATA && cnt_q == CW'(DW - 1)) |=> !oe_q);

  // R6: an undriven output sits at the released level
  p_release_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> out_q);

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
  import mdio_phy_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up_i,
  input  logic          wr_en_i,
  input  logic [FW-1:0] idx_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o
);

  logic [DW-1:0] mem_q [NREG];
  logic          link_q;
  logic [DW-1:0] adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b1;
    else        link_q <= link_up_i;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem_q[g] <= reg_reset(g);
      else if (wr_en_i && idx_i == FW'(g))       mem_q[g] <= wr_data_i;
    end
  end

  assign adv = mem_q[REG_ADV];

  always_comb begin
    if (idx_i == FW'(REG_BMSR)) begin
      rd_data_o = link_q ? 16'h782C : '0;
    end else if (idx_i == FW'(REG_PARTNER)) begin
      rd_data_o = 16'h4001 | (adv & 16'h01E0);
    end else if (idx_i == FW'(REG_DIAG)) begin
      rd_data_o = '0;
      if (link_q) begin
        rd_data_o[10] = adv[7] | adv[8];
        rd_data_o[11] = adv[8] | adv[6];
      end
    end else begin
      rd_data_o = mem_q[idx_i];
    end
  end

  // R5: a write pulse lands in the addressed register
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en_i) |-> mem_q[$past(idx_i)] == $past(wr_data_i));

endmodule

// File: rtl/mdio_phy_target.sv
module mdio_phy_target
  import mdio_phy_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_MIN     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdc_i,
  input  logic          mdio_i,
  input  logic          link_up_i,
  input  logic [FW-1:0] phy_addr_i,
  output logic          mdio_o,
  output logic          mdio_oe_o
);

  logic          mdc_s, mdio_s, rise, fall;
  logic [FW-1:0] reg_idx;
  logic          wr_en;
  logic [DW-1:0] wr_data, rd_data;

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc_i    (mdc_i),
    .mdio_i   (mdio_i),
    .mdc_s_o  (mdc_s),
    .mdio_s_o (mdio_s),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  mdio_frame_dec #(.PRE_MIN(PRE_MIN)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdc_s_i    (mdc_s),
    .mdio_s_i   (mdio_s),
    .phy_addr_i (phy_addr_i),
    .rd_data_i  (rd_data),
    .reg_idx_o  (reg_idx),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o)
  );

  mdio_phy_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up_i (link_up_i),
    .wr_en_i   (wr_en),
    .idx_i     (reg_idx),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data)
  );

endmodule

// File: tb/mdio_phy_target_bench.sv
module mdio_phy_target_bench;

  localparam int HALF = 8;
  localparam logic [4:0] STRAP = 5'd1;

  logic clk, rst_n, mdc_i, mdio_i, link_up_i;
  logic [4:0] phy_addr_i;
  logic mdio_o, mdio_oe_o;

  int n_chk, n_fail;
  logic [15:0] mregs [32];
  logic [15:0] rd;

  mdio_phy_target u_mdio_phy_target (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_i(mdio_i),
    .link_up_i(link_up_i), .phy_addr_i(phy_addr_i),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(input logic [4:0] r);
    logic [15:0] a, v;
    a = mregs[4];
    v = 16'h0;
    case (r)
      5'd1:  v = link_up_i ? 16'h782C : 16'h0;
      5'd5:  v = 16'h4001 | (a & 16'h01E0);
      5'd18: if (link_up_i) begin
               v[10] = a[7] | a[8];
               v[11] = a[8] | a[6];
             end
      default: v = mregs[r];
    endcase
    return v;
  endfunction

  // one bus bit: low half then high half, outputs compared on each late clock
  task automatic bit_cyc(input logic b, input string tag,
                         input logic lo_oe, input logic lo_o,
                         input logic hi_oe, input logic hi_o,
                         output logic cap);
    mdc_i  = 1'b0;
    mdio_i = b;
    for (int c = 0; c < HALF; c++) begin
      @(negedge clk);
      if (c >= 5) begin
        chk(tag, {15'b0, mdio_oe_o}, {15'b0, lo_oe});
        chk(tag, {15'b0, mdio_o}, {15'b0, lo_o});
      end
    end
    cap   = mdio_o;
    mdc_i = 1'b1;
    for (int c = 0; c < HALF; c++) begin
      @(negedge clk);
      if (c >= 5) begin
        chk(tag, {15'b0, mdio_oe_o}, {15'b0, hi_oe});
        chk(tag, {15'b0, mdio_o}, {15'b0, hi_o});
      end
    end
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input int pre, input string tag,
                       output logic [15:0] rdv);
    logic hit, is_rd, cap, b, lo_o;
    logic [15:0] exp;
    logic [13:0] hdr;
    hit   = (pa == STRAP) && (pre >= 32);
    is_rd = hit && (op == 2'b10);
    exp   = model_rd(ra);
    hdr   = {2'b01, op, pa, ra};
    for (int i = 0; i < pre; i++) bit_cyc(1'b1, tag, 1'b0, 1'b1, 1'b0, 1'b1, cap);
    for (int i = 13; i >= 0; i--) bit_cyc(hdr[i], tag, 1'b0, 1'b1, 1'b0, 1'b1, cap);
    bit_cyc(1'b1, tag, 1'b0, 1'b1, 1'b0, 1'b1, cap);
    bit_cyc((op == 2'b10) ? 1'b1 : 1'b0, tag, 1'b0, 1'b1, is_rd, 1'b1, cap);
    rdv = '0;
    for (int i = 15; i >= 0; i--) begin
      b    = (op == 2'b10) ? 1'b1 : wd[i];
      lo_o = is_rd ? exp[i] : 1'b1;
      bit_cyc(b, tag, is_rd, lo_o, (i == 0) ? 1'b0 : is_rd, (i == 0) ? 1'b1 : lo_o, cap);
      rdv[i] = cap;
    end
    if (hit && op != 2'b10) mregs[ra] = wd;
  endtask

  task automatic rd_chk(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] exp,
                        input string tag);
    logic [15:0] v;
    frame(2'b10, pa, ra, 16'h0, 32, tag, v);
    chk(tag, v, exp);
  endtask

  task automatic wr(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                    input logic [15:0] wd, input string tag);
    logic [15:0] v;
    frame(op, pa, ra, wd, 32, tag, v);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    for (int i = 0; i < 32; i++) mregs[i] = 16'h0;
    mregs[0] = 16'h3100; mregs[2] = 16'h0300; mregs[3] = 16'hE400; mregs[4] = 16'h01E1;
    rst_n = 1'b0; mdc_i = 1'b0; mdio_i = 1'b1; link_up_i = 1'b1; phy_addr_i = STRAP;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset", {15'b0, mdio_oe_o}, 16'h0);
    chk("R1 out after reset", {15'b0, mdio_o}, 16'h1);

    rd_chk(STRAP, 5'd0, 16'h3100, "R1 reg0");
    rd_chk(STRAP, 5'd2, 16'h0300, "R1 reg2");
    rd_chk(STRAP, 5'd3, 16'hE400, "R1 reg3");
    rd_chk(STRAP, 5'd4, 16'h01E1, "R1 reg4");
    rd_chk(STRAP, 5'd6, 16'h0000, "R1 reg6");

    rd_chk(STRAP, 5'd1,  16'h782C, "R7 reg1 link up");
    rd_chk(STRAP, 5'd5,  16'h41E1, "R8 reg5 default");
    rd_chk(STRAP, 5'd18, 16'h0C00, "R9 reg18 default");

    wr(2'b01, STRAP, 5'd4, 16'h0020, "R5 write adv");
    rd_chk(STRAP, 5'd4,  16'h0020, "R5 readback adv");
    rd_chk(STRAP, 5'd5,  16'h4021, "R8 reg5 10half");
    rd_chk(STRAP, 5'd18, 16'h0000, "R9 reg18 10half");
    wr(2'b01, STRAP, 5'd4, 16'h0040, "R5 write adv");
    rd_chk(STRAP, 5'd18, 16'h0800, "R9 reg18 10full");
    wr(2'b01, STRAP, 5'd4, 16'h0080, "R5 write adv");
    rd_chk(STRAP, 5'd18, 16'h0400, "R9 reg18 100half");

    wr(2'b11, STRAP, 5'd7,  16'hA5C3, "R3 op11 write");
    rd_chk(STRAP, 5'd7,  16'hA5C3, "R3 op11 readback");
    wr(2'b00, STRAP, 5'd31, 16'h1234, "R3 op00 write");
    rd_chk(STRAP, 5'd31, 16'h1234, "R3 op00 readback");

    wr(2'b01, STRAP, 5'd1, 16'h0000, "R7 write reg1");
    rd_chk(STRAP, 5'd1, 16'h782C, "R7 reg1 after write");

    wr(2'b01, 5'd3, 5'd7, 16'h0F0F, "R6 foreign write");
    rd_chk(5'd3, 5'd7, 16'hFFFF, "R6 foreign read");
    rd_chk(STRAP, 5'd7, 16'hA5C3, "R6 reg7 untouched");

    frame(2'b10, STRAP, 5'd0, 16'h0, 31, "R2 short preamble", rd);
    chk("R2 short preamble read", rd, 16'hFFFF);
    rd_chk(STRAP, 5'd0, 16'h3100, "R2 full preamble after short");

    link_up_i = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk(STRAP, 5'd1,  16'h0000, "R7 reg1 link down");
    rd_chk(STRAP, 5'd18, 16'h0000, "R9 reg18 link down");
    rd_chk(STRAP, 5'd5,  16'h4081, "R8 reg5 link down");
    link_up_i = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(STRAP, 5'd1, 16'h782C, "R7 reg1 link back");

    finish_run();
  end

endmodule